// File: doc/BRIEF.md
# Speculation Token and Load-Alias Tracker

This block supports two kinds of load speculation in a processor core. A control-speculative load that faults does not trap. It marks its destination register with a deferred-fault token, and that token travels through ordinary operations that read the register. A later token check on a consuming register tells the front end to redirect to recovery code when the token is set.

For data speculation, an advanced load may be hoisted above stores that could alias it. When it completes, it records its destination register and its 8-byte address granule in a small fully associative table. Any store that hits the granule removes the record. An advanced check then passes only if a live record still exists for its register. Otherwise it asks for the load to be redone through recovery.

The block sits beside the register file's write port. It watches load completions, ALU writebacks, store addresses and check requests, and answers each check one cycle later with a done pulse and a recover flag.

Top module: `spec_track`

## Requirements
- R1: After reset all tokens are clear, the table holds no live entry, and `chk_done` and `chk_recover` are low.
- R2: A load completion carries a 2-bit kind. Bit 0 set means control-speculative and bit 1 set means advanced. For kinds 1 and 3 the destination token becomes the value of `ld_fault`.
- R3: A completion of kind 0 (a plain write) or kind 2 clears the destination token, whatever `ld_fault` is.
- R4: An operation writes its destination token as the OR of its two source tokens. If a load completes to the same register in the same cycle, the load's token value wins.
- R5: A token check (`chk_kind`=0) raises `chk_done` exactly one cycle later. It raises `chk_recover` in that same cycle if and only if the register's token was set.
- R6: A load of kind 2 or 3 writes an entry with its register and address granule. The entry is live unless the kind is 3 and `ld_fault` is set.
- R7: A store kills, in one cycle, every live entry whose address bits [AW-1:3] equal those of the store. An entry written in that same cycle stays live.
- R8: An advanced check (`chk_kind`=1) raises `chk_recover` one cycle later if and only if no live entry exists for the register.
- R9: An allocation reuses the slot of a live entry with the same register and leaves the victim pointer unchanged. Otherwise it fills the slot at a round-robin victim pointer and advances the pointer. As a result, the 17th distinct allocation overwrites the first.
- R10: A check sees the state as it stood before any load, operation or store presented in the same cycle.
- R11: No register ever has more than one live entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load or plain write completes |
| ld_kind | input | 2 | Bit 0 control-speculative, bit 1 advanced |
| ld_reg | input | RW | Destination register |
| ld_addr | input | AW | Load address |
| ld_fault | input | 1 | Load hit an exception |
| op_valid | input | 1 | Ordinary operation writes back |
| op_src_a | input | RW | First source register |
| op_src_b | input | RW | Second source register |
| op_dst | input | RW | Destination register |
| st_valid | input | 1 | Store address valid |
| st_addr | input | AW | Store address |
| chk_valid | input | 1 | Check request |
| chk_kind | input | 1 | 0 token check, 1 advanced check |
| chk_reg | input | RW | Register under check |
| chk_done | output | 1 | Check answered (one cycle after request) |
| chk_recover | output | 1 | Redirect to recovery code |

## Verification
Token checks are exercised after faulting and clean speculative loads, after a plain overwrite, and through chains of operations. These cases separate setting, clearing and propagating a token. Advanced checks are run in several situations: with no store, with a store in the same granule but at a different byte, with a store to a neighbouring granule, and with one store hitting two entries. These separate the granule compare and the multi-kill. The table is then filled past its depth, and a register is re-allocated in place, to expose the victim order. Checks issued in the same cycle as a conflicting store or load show that the check reads the state from before those updates.

// File: rtl/spec_track.sv
module spec_track #(
  parameter int NREG    = 32,
  parameter int AW      = 32,
  parameter int ENTRIES = 16,
  parameter int GRAN    = 3,
  localparam int RW = $clog2(NREG),
  localparam int EW = $clog2(ENTRIES),
  localparam int TW = AW - GRAN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [1:0]    ld_kind,
  input  logic [RW-1:0] ld_reg,
  input  logic [AW-1:0] ld_addr,
  input  logic          ld_fault,
  input  logic          op_valid,
  input  logic [RW-1:0] op_src_a,
  input  logic [RW-1:0] op_src_b,
  input  logic [RW-1:0] op_dst,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic          chk_valid,
  input  logic          chk_kind,
  input  logic [RW-1:0] chk_reg,
  output logic          chk_done,
  output logic          chk_recover
);

  logic [NREG-1:0]    tok;
  logic [ENTRIES-1:0] ent_v;
  logic [RW-1:0]      ent_r [ENTRIES];
  logic [TW-1:0]      ent_a [ENTRIES];
  logic [EW-1:0]      vptr;

  logic [ENTRIES-1:0] st_hit, chk_hit;
  logic               same_hit;
  logic [EW-1:0]      same_idx;

  wire          alloc = ld_valid & ld_kind[1];
  wire          dfail = ld_kind[0] & ld_fault;
  wire [EW-1:0] wslot = same_hit ? same_idx : vptr;

  always_comb begin
    same_hit = 1'b0;
    same_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      st_hit[i]  = st_valid & ent_v[i] & (ent_a[i] == st_addr[AW-1:GRAN]);
      chk_hit[i] = ent_v[i] & (ent_r[i] == chk_reg);
      if (ent_v[i] && ent_r[i] == ld_reg) begin
        same_hit = 1'b1;
        same_idx = EW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tok <= '0;
    end else begin
      if (op_valid) tok[op_dst] <= tok[op_src_a] | tok[op_src_b];
      if (ld_valid) tok[ld_reg] <= dfail;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v <= '0;
      vptr  <= '0;
    end else begin
      ent_v <= ent_v & ~st_hit;
      if (alloc) begin
        ent_v[wslot] <= ~dfail;
        if (!same_hit) vptr <= vptr + EW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      ent_r[wslot] <= ld_reg;
      ent_a[wslot] <= ld_addr[AW-1:GRAN];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_done    <= 1'b0;
      chk_recover <= 1'b0;
    end else begin
      chk_done    <= chk_valid;
      chk_recover <= chk_valid & (chk_kind ? ~|chk_hit : tok[chk_reg]);
    end
  end

endmodule

module spec_track_chk #(
  parameter int RW      = 5,
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ld_valid,
  input logic [1:0]         ld_kind,
  input logic [RW-1:0]      ld_reg,
  input logic               ld_fault,
  input logic               chk_valid,
  input logic               chk_kind,
  input logic [RW-1:0]      chk_reg,
  input logic               chk_done,
  input logic               chk_recover,
  input logic [ENTRIES-1:0] chk_hit
);

  // R5
  recover_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_recover |-> chk_done);

  // R5
  done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> chk_done);

  // R5
  no_stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_done |-> $past(chk_valid));

  // R2
  fault_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ld_valid && ld_kind == 2'd1 && ld_fault) && chk_valid && !chk_kind
      && chk_reg == $past(ld_reg)) |=> chk_recover);

  // R8
  fresh_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ld_valid && ld_kind == 2'd2) && chk_valid && chk_kind
      && chk_reg == $past(ld_reg)) |=> !chk_recover);

  // R11
  single_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chk_hit));

endmodule

bind spec_track spec_track_chk #(.RW(RW), .ENTRIES(ENTRIES)) chk_i (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_kind(ld_kind),
  .ld_reg(ld_reg), .ld_fault(ld_fault), .chk_valid(chk_valid),
  .chk_kind(chk_kind), .chk_reg(chk_reg), .chk_done(chk_done),
  .chk_recover(chk_recover), .chk_hit(chk_hit)
);

// File: tb/spec_track_tb_top.sv
`timescale 1ns/1ps
module spec_track_tb_top;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic ld_valid = 0, ld_fault = 0, op_valid = 0, st_valid = 0, chk_valid = 0, chk_kind = 0;
  logic [1:0] ld_kind = 0;
  logic [4:0] ld_reg = 0, op_src_a = 0, op_src_b = 0, op_dst = 0, chk_reg = 0;
  logic [31:0] ld_addr = 0, st_addr = 0;
  logic chk_done, chk_recover;

  spec_track dut_i (.*);

  int total = 0, bad = 0;
  bit finished = 0;
  bit exp_q[$];
  int req_q[$];
  int reg_q[$];

  bit mtok [32];
  bit mv [16];
  int mr [16];
  logic [28:0] ma [16];
  int mptr = 0;

  task automatic drive(bit lv, int lk, int lr, logic [31:0] la, bit lf,
                       bit ov, int oa, int ob, int od,
                       bit sv, logic [31:0] sa,
                       bit cv, bit ck, int cr, int rq);
    bit e, opv, hit;
    int hidx, slot;
    @(negedge clk);
    ld_valid = lv; ld_kind = 2'(lk); ld_reg = 5'(lr); ld_addr = la; ld_fault = lf;
    op_valid = ov; op_src_a = 5'(oa); op_src_b = 5'(ob); op_dst = 5'(od);
    st_valid = sv; st_addr = sa;
    chk_valid = cv; chk_kind = ck; chk_reg = 5'(cr);
    if (cv) begin
      if (ck) begin
        e = 1;
        for (int i = 0; i < 16; i++) if (mv[i] && mr[i] == cr) e = 0;
      end else e = mtok[cr];
      exp_q.push_back(e); req_q.push_back(rq); reg_q.push_back(cr);
    end
    opv = mtok[oa] | mtok[ob];
    hit = 0; hidx = 0;
    for (int i = 0; i < 16; i++) if (mv[i] && mr[i] == lr) begin hit = 1; hidx = i; end
    if (ov) mtok[od] = opv;
    if (lv) mtok[lr] = (lk % 2 == 1) && lf;
    if (sv) for (int i = 0; i < 16; i++) if (mv[i] && ma[i] == sa[31:3]) mv[i] = 0;
    if (lv && lk >= 2) begin
      slot = hit ? hidx : mptr;
      mv[slot] = !((lk % 2 == 1) && lf);
      mr[slot] = lr; ma[slot] = la[31:3];
      if (!hit) mptr = (mptr + 1) % 16;
    end
  endtask

  task automatic idle();
    drive(0,0,0,0,0, 0,0,0,0, 0,0, 0,0,0,0);
  endtask
  task automatic ld(int k, int r, logic [31:0] a, bit f);
    drive(1,k,r,a,f, 0,0,0,0, 0,0, 0,0,0,0);
  endtask
  task automatic op(int a, int b, int d);
    drive(0,0,0,0,0, 1,a,b,d, 0,0, 0,0,0,0);
  endtask
  task automatic st(logic [31:0] a);
    drive(0,0,0,0,0, 0,0,0,0, 1,a, 0,0,0,0);
  endtask
  task automatic chk(bit k, int r, int rq);
    drive(0,0,0,0,0, 0,0,0,0, 0,0, 1,k,r,rq);
  endtask

  always @(negedge clk) begin
    if (rst_n && chk_done && !finished) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R5 unexpected chk_done: actual=1 expected=0");
      end else begin
        bit e; int rq; int r;
        e = exp_q.pop_front(); rq = req_q.pop_front(); r = reg_q.pop_front();
        if (chk_recover !== e) begin
          bad++;
          $display("FAIL R%0d reg %0d chk_recover: actual=%0b expected=%0b", rq, r, chk_recover, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1; total++; bad++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    foreach (mtok[i]) mtok[i] = 0;
    foreach (mv[i]) begin mv[i] = 0; mr[i] = 0; ma[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (chk_done !== 0 || chk_recover !== 0) begin
      bad++;
      $display("FAIL R1 outputs after reset: actual=%0b%0b expected=00", chk_done, chk_recover);
    end
    rst_n = 1;
    // R1: clean state
    chk(0, 5, 1); chk(1, 5, 1);
    // R2, R5: faulting and clean speculative loads
    ld(1, 5, 32'h40, 1); chk(0, 5, 2);
    ld(1, 6, 32'h48, 0); chk(0, 6, 2);
    // R3: plain write and advanced load clear the token
    ld(0, 5, 0, 1); chk(0, 5, 3);
    ld(1, 4, 0, 1); ld(2, 4, 32'h500, 1); chk(0, 4, 3);
    // R4: propagation
    ld(1, 7, 0, 1); op(1, 7, 8); chk(0, 8, 4);
    op(8, 2, 9); chk(0, 9, 4);
    op(1, 2, 3); chk(0, 3, 4);
    drive(1,0,10,0,0, 1,7,7,10, 0,0, 0,0,0,0); chk(0, 10, 4);
    // R6, R8: advanced load then check
    ld(2, 11, 32'h100, 0); chk(1, 11, 8);
    chk(1, 12, 8);
    // R7: same granule kills, neighbour granule does not
    st(32'h104); chk(1, 11, 7);
    ld(2, 12, 32'h200, 0); st(32'h208); chk(1, 12, 7);
    ld(2, 13, 32'h300, 0); ld(2, 14, 32'h300, 0); st(32'h307);
    chk(1, 13, 7); chk(1, 14, 7);
    // R7: allocation beats same-cycle store
    drive(1,2,15,32'h600,0, 0,0,0,0, 1,32'h600, 0,0,0,0); chk(1, 15, 7);
    // R6: speculative advanced load with fault leaves no live entry
    ld(3, 16, 32'h700, 1); chk(1, 16, 6); chk(0, 16, 2);
    ld(3, 17, 32'h708, 0); chk(1, 17, 6);
    // R10: check ignores same-cycle store and load
    ld(2, 18, 32'h800, 0);
    drive(0,0,0,0,0, 0,0,0,0, 1,32'h800, 1,1,18,10); chk(1, 18, 10);
    drive(1,1,19,0,1, 0,0,0,0, 0,0, 1,0,19,10); chk(0, 19, 10);
    // R9: fill beyond depth, then in-place reuse
    for (int i = 0; i < 16; i++) ld(2, 16 + i, 32'h1000 + 32'(i) * 8, 0);
    ld(2, 2, 32'h2000, 0);
    for (int i = 16; i < 32; i++) chk(1, i, 9);
    chk(1, 2, 9);
    ld(2, 2, 32'h2100, 0);
    ld(2, 3, 32'h2200, 0);
    for (int i = 16; i < 32; i++) chk(1, i, 9);
    chk(1, 2, 9); chk(1, 3, 11);
    st(32'h2000); chk(1, 2, 9);
    idle(); idle(); idle();
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R5 missing chk_done: actual=%0d pending expected=0", exp_q.size());
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule